// File: doc/BRIEF.md
# Radio Warm-Up/Warm-Down Event Sequencer

This block drives a bank of radio control lines through a timed list of events when a receive or transmit path is brought up and later shut down. Software loads an event table ahead of time. Each entry holds a cycle offset measured from the start of its phase, the pattern of control lines to apply at that offset, and a flag that marks it as the last entry of its phase. A sequence is launched either by a software start pulse or by a pulse from an external timer, whichever source is selected. The warm-up phase then runs to its end without further host action and leaves the control lines holding their final pattern.

The table is split into regions in one of two ways. In the separate layout, receive and transmit each have their own warm-up and warm-down lists. In the combined layout, a single warm-up list and a single warm-down list are shared by both directions. A warm-down request starts the warm-down phase, either at once or after a programmed number of cycles. The block pulses one of three maskable interrupt lines when a phase ends. It flags a start request that arrives while it is not idle, and it lets software force any control line to a fixed value.

Top module: `radio_seq_mgr`

## Requirements
- R1: After reset, `radio_ctl` is all zero, `seq_irq` is 3'b000 and `seq_err` is 0.
- R2: When a phase is entered at clock edge k, the table entry with offset d is applied to the control lines at edge k+1+d, provided the offsets in the region strictly increase. The lines keep their value between events, while idle, while holding after warm-up, and while waiting on a delayed warm-down.
- R3: With `combined`=0, the table is split into four regions of N/4 entries each. Receive warm-up starts at index 0, receive warm-down at N/4, transmit warm-up at N/2, and transmit warm-down at 3N/4. `sel_tx`=1 selects transmit.
- R4: With `combined`=1, warm-up uses entries 0 to N/2-1 and warm-down uses entries N/2 to N-1, whatever the value of `sel_tx`.
- R5: With `start_src`=0, only `sw_start` launches a sequence. With `start_src`=1, only `tmr_pulse` launches one. The unselected source has no effect on any output.
- R6: If the selected start source pulses while the block is not idle, the pulse is ignored and `seq_err` is high for exactly one cycle, starting the cycle after that edge. The running phase continues unchanged.
- R7: A phase ends on the first entry whose last flag is set, or on the final entry of its region if no entry in the region has the flag. At the end of warm-up the block holds its outputs. At the end of warm-down it returns to idle.
- R8: `wd_req` sampled while the block holds after warm-up starts warm-down at that same edge when `wd_delayed`=0 or `wd_delay`=0. When `wd_delayed`=1 and `wd_delay`=D>0, warm-down starts D edges later. `wd_req` is ignored in every other state.
- R9: `seq_irq[0]` marks the end of a receive warm-up, `seq_irq[1]` the end of a transmit warm-up, and `seq_irq[2]` the end of any warm-down. Each is a one-cycle pulse in the same cycle the final pattern appears, and each is suppressed when its `irq_mask` bit (1 = enabled) is 0.
- R10: For each bit i, `radio_ctl[i]` equals `ovr_val[i]` when `ovr_en[i]`=1 and the sequencer value otherwise. The override takes effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Event table write strobe |
| tbl_addr | input | $clog2(N) | Event table write index |
| tbl_off | input | TIME_W | Cycle offset of the entry |
| tbl_pat | input | OUT_W | Control pattern of the entry |
| tbl_last | input | 1 | Last-entry flag of the entry |
| start_src | input | 1 | 0 = software start, 1 = timer pulse |
| sw_start | input | 1 | Software start pulse |
| tmr_pulse | input | 1 | Start pulse from the selected timer |
| sel_tx | input | 1 | 0 = receive, 1 = transmit sequence |
| combined | input | 1 | 1 = shared warm-up/warm-down lists |
| wd_req | input | 1 | Warm-down request |
| wd_delayed | input | 1 | 1 = apply the warm-down delay |
| wd_delay | input | DLY_W | Warm-down delay in cycles |
| irq_mask | input | 3 | Interrupt enables |
| ovr_en | input | OUT_W | Per-line override enable |
| ovr_val | input | OUT_W | Per-line override value |
| radio_ctl | output | OUT_W | Radio control lines |
| seq_irq | output | 3 | End-of-phase interrupt pulses |
| seq_err | output | 1 | Start-while-busy pulse |

## Verification
The bench builds the block with its defaults: N=32, OUT_W=8, TIME_W=12 and DLY_W=8. With N=32, separate regions hold 8 entries and combined regions hold 16. That is short enough that sequences ending on the region limit, with no last flag, fit easily into the run. Offsets step by 1 to 4 cycles, so every event boundary and each interrupt cycle can be checked cycle by cycle. Warm-down delays of 0 to 6 exercise the direct path, the one-cycle delay and longer waits.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_UP   = 3'd1,
    S_ON   = 3'd2,
    S_WAIT = 3'd3,
    S_DN   = 3'd4
  } rsm_st_e;

  // first table index of a phase region
  function automatic int rgn_base(int n, logic tx, logic comb, logic dn);
    int q;
    q = n / 4;
    if (comb) return dn ? 2 * q : 0;
    return (tx ? 2 * q : 0) + (dn ? q : 0);
  endfunction

  // number of entries in a phase region
  function automatic int rgn_len(int n, logic comb);
    return comb ? n / 2 : n / 4;
  endfunction

endpackage

// File: rtl/rsm_evt_table.sv
module rsm_evt_table #(
  parameter int N      = 32,
  parameter int OUT_W  = 8,
  parameter int TIME_W = 12,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     waddr,
  input  logic [TIME_W-1:0] woff,
  input  logic [OUT_W-1:0]  wpat,
  input  logic              wlast,
  input  logic [IW-1:0]     raddr,
  output logic [TIME_W-1:0] roff,
  output logic [OUT_W-1:0]  rpat,
  output logic              rlast
);

  logic [TIME_W-1:0] off_m  [N];
  logic [OUT_W-1:0]  pat_m  [N];
  logic              last_m [N];

  always_ff @(posedge clk) begin
    if (we) begin
      off_m[waddr]  <= woff;
      pat_m[waddr]  <= wpat;
      last_m[waddr] <= wlast;
    end
  end

  assign roff  = off_m[raddr];
  assign rpat  = pat_m[raddr];
  assign rlast = last_m[raddr];

endmodule

// File: rtl/rsm_fsm.sv
module rsm_fsm
  import rsm_pkg::*;
#(
  parameter int N      = 32,
  parameter int OUT_W  = 8,
  parameter int TIME_W = 12,
  parameter int DLY_W  = 8,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_src,
  input  logic              sw_start,
  input  logic              tmr_pulse,
  input  logic              sel_tx,
  input  logic              combined,
  input  logic              wd_req,
  input  logic              wd_delayed,
  input  logic [DLY_W-1:0]  wd_delay,
  input  logic [2:0]        irq_mask,
  output logic [IW-1:0]     rd_idx,
  input  logic [TIME_W-1:0] rd_off,
  input  logic [OUT_W-1:0]  rd_pat,
  input  logic              rd_last,
  output logic [OUT_W-1:0]  seq_out,
  output logic [2:0]        irq,
  output logic              err
);

  rsm_st_e           st_q, st_d;
  logic [TIME_W-1:0] tcnt_q, tcnt_d;
  logic [IW-1:0]     idx_q, idx_d, lim_q, lim_d;
  logic              tx_q, tx_d, comb_q, comb_d;
  logic [DLY_W-1:0]  dcnt_q, dcnt_d;
  logic [OUT_W-1:0]  out_q, out_d;
  logic [2:0]        irq_q, irq_d;
  logic              err_q, err_d;
  logic              start_ev, dn_go, run_en;

  assign start_ev = start_src ? tmr_pulse : sw_start;
  assign run_en   = (st_q == S_UP) || (st_q == S_DN);

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    idx_d  = idx_q;
    lim_d  = lim_q;
    tx_d   = tx_q;
    comb_d = comb_q;
    dcnt_d = dcnt_q;
    out_d  = out_q;
    irq_d  = '0;
    dn_go  = 1'b0;
    err_d  = start_ev && (st_q != S_IDLE);
    unique case (st_q)
      S_IDLE: begin
        if (start_ev) begin
          st_d   = S_UP;
          tcnt_d = '0;
          tx_d   = sel_tx;
          comb_d = combined;
          idx_d  = IW'(rgn_base(N, sel_tx, combined, 1'b0));
          lim_d  = IW'(rgn_base(N, sel_tx, combined, 1'b0) + rgn_len(N, combined) - 1);
        end
      end
      S_UP, S_DN: begin
        if (tcnt_q != '1) tcnt_d = tcnt_q + TIME_W'(1);
        if (tcnt_q >= rd_off) begin
          out_d = rd_pat;
          if (rd_last || (idx_q == lim_q)) begin
            if (st_q == S_UP) begin
              st_d = S_ON;
              if (tx_q) irq_d[1] = irq_mask[1];
              else      irq_d[0] = irq_mask[0];
            end else begin
              st_d     = S_IDLE;
              irq_d[2] = irq_mask[2];
            end
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      S_ON: begin
        if (wd_req) begin
          if (wd_delayed && (wd_delay != '0)) begin
            st_d   = S_WAIT;
            dcnt_d = wd_delay;
          end else begin
            dn_go = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (dcnt_q <= DLY_W'(1)) dn_go = 1'b1;
        else                     dcnt_d = dcnt_q - DLY_W'(1);
      end
      default: st_d = S_IDLE;
    endcase
    if (dn_go) begin
      st_d   = S_DN;
      tcnt_d = '0;
      idx_d  = IW'(rgn_base(N, tx_q, comb_q, 1'b1));
      lim_d  = IW'(rgn_base(N, tx_q, comb_q, 1'b1) + rgn_len(N, comb_q) - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      lim_q  <= '0;
      tx_q   <= 1'b0;
      comb_q <= 1'b0;
      dcnt_q <= '0;
      out_q  <= '0;
      irq_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      err_q <= err_d;
      if (run_en || dn_go || (st_q == S_IDLE)) begin
        tcnt_q <= tcnt_d;
        idx_q  <= idx_d;
        lim_q  <= lim_d;
      end
      if (st_q == S_IDLE) begin
        tx_q   <= tx_d;
        comb_q <= comb_d;
      end
      if ((st_q == S_ON) || (st_q == S_WAIT)) dcnt_q <= dcnt_d;
      if (run_en) out_q <= out_d;
    end
  end

  assign rd_idx  = idx_q;
  assign seq_out = out_q;
  assign irq     = irq_q;
  assign err     = err_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE || st_q == S_ON || st_q == S_WAIT) |=> $stable(seq_out));

  // R6
  err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(st_q) != S_IDLE));

  // R9
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R7
  dn_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[2] |-> (st_q == S_IDLE));

  // R8
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |=> (st_q == S_WAIT || st_q == S_DN));

endmodule

// File: rtl/rsm_ovr.sv
module rsm_ovr #(
  parameter int OUT_W = 8
) (
  input  logic [OUT_W-1:0] seq_in,
  input  logic [OUT_W-1:0] ovr_en,
  input  logic [OUT_W-1:0] ovr_val,
  output logic [OUT_W-1:0] ctl_out
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign ctl_out[i] = ovr_en[i] ? ovr_val[i] : seq_in[i];
  end

endmodule

// File: rtl/radio_seq_mgr.sv
module radio_seq_mgr #(
  parameter int N      = 32,
  parameter int OUT_W  = 8,
  parameter int TIME_W = 12,
  parameter int DLY_W  = 8,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IW-1:0]     tbl_addr,
  input  logic [TIME_W-1:0] tbl_off,
  input  logic [OUT_W-1:0]  tbl_pat,
  input  logic              tbl_last,
  input  logic              start_src,
  input  logic              sw_start,
  input  logic              tmr_pulse,
  input  logic              sel_tx,
  input  logic              combined,
  input  logic              wd_req,
  input  logic              wd_delayed,
  input  logic [DLY_W-1:0]  wd_delay,
  input  logic [2:0]        irq_mask,
  input  logic [OUT_W-1:0]  ovr_en,
  input  logic [OUT_W-1:0]  ovr_val,
  output logic [OUT_W-1:0]  radio_ctl,
  output logic [2:0]        seq_irq,
  output logic              seq_err
);

  logic [1:0]        rst_sq;
  logic              rst_i;
  logic [IW-1:0]     rd_idx;
  logic [TIME_W-1:0] rd_off;
  logic [OUT_W-1:0]  rd_pat;
  logic              rd_last;
  logic [OUT_W-1:0]  seq_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  rsm_evt_table #(.N(N), .OUT_W(OUT_W), .TIME_W(TIME_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .woff(tbl_off),
    .wpat(tbl_pat), .wlast(tbl_last), .raddr(rd_idx),
    .roff(rd_off), .rpat(rd_pat), .rlast(rd_last)
  );

  rsm_fsm #(.N(N), .OUT_W(OUT_W), .TIME_W(TIME_W), .DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst_n(rst_i), .start_src(start_src), .sw_start(sw_start),
    .tmr_pulse(tmr_pulse), .sel_tx(sel_tx), .combined(combined),
    .wd_req(wd_req), .wd_delayed(wd_delayed), .wd_delay(wd_delay),
    .irq_mask(irq_mask), .rd_idx(rd_idx), .rd_off(rd_off), .rd_pat(rd_pat),
    .rd_last(rd_last), .seq_out(seq_out), .irq(seq_irq), .err(seq_err)
  );

  rsm_ovr #(.OUT_W(OUT_W)) u_ovr (
    .seq_in(seq_out), .ovr_en(ovr_en), .ovr_val(ovr_val), .ctl_out(radio_ctl)
  );

endmodule

// File: tb/sim_radio_seq_mgr.sv
module sim_radio_seq_mgr;
  localparam int N = 32, OW = 8, TW = 12, DW = 8, IW = 5, Q = N / 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tbl_we, tbl_last, start_src, sw_start, tmr_pulse, sel_tx, combined;
  logic wd_req, wd_delayed;
  logic [IW-1:0] tbl_addr;
  logic [TW-1:0] tbl_off;
  logic [OW-1:0] tbl_pat, ovr_en, ovr_val, radio_ctl;
  logic [DW-1:0] wd_delay;
  logic [2:0] irq_mask, seq_irq;
  logic seq_err;

  radio_seq_mgr #(.N(N), .OUT_W(OW), .TIME_W(TW), .DLY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_off(tbl_off),
    .tbl_pat(tbl_pat), .tbl_last(tbl_last), .start_src(start_src), .sw_start(sw_start),
    .tmr_pulse(tmr_pulse), .sel_tx(sel_tx), .combined(combined), .wd_req(wd_req),
    .wd_delayed(wd_delayed), .wd_delay(wd_delay), .irq_mask(irq_mask), .ovr_en(ovr_en),
    .ovr_val(ovr_val), .radio_ctl(radio_ctl), .seq_irq(seq_irq), .seq_err(seq_err)
  );

  int n_tests = 0, n_fail = 0;
  logic [TW-1:0] m_off [N];
  logic [OW-1:0] m_pat [N];
  logic          m_last[N];
  logic [OW-1:0] cur;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int off, int pat, logic last);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = IW'(a); tbl_off = TW'(off); tbl_pat = OW'(pat); tbl_last = last;
    m_off[a] = TW'(off); m_pat[a] = OW'(pat); m_last[a] = last;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic fill(int base, int len, bit no_last);
    int t, lp;
    t  = $urandom_range(0, 3);
    lp = no_last ? len : $urandom_range(0, len);
    for (int j = 0; j < len; j++) begin
      wr(base + j, t, $urandom, (j == lp));
      t += $urandom_range(1, 4);
    end
  endtask

  function automatic int up_base(bit tx, bit comb);
    return comb ? 0 : (tx ? 2 * Q : 0);
  endfunction
  function automatic int dn_base(bit tx, bit comb);
    return comb ? 2 * Q : (tx ? 3 * Q : Q);
  endfunction
  function automatic int rlen(bit comb);
    return comb ? 2 * Q : Q;
  endfunction

  // caller has just set the trigger at a negedge
  task automatic run_phase(string req, int base, int len, int shift, int ibit, int inj);
    int e, j, fin, exp_irq;
    e = base + len - 1;
    for (int i = base + len - 1; i >= base; i--) if (m_last[i]) e = i;
    fin = int'(m_off[e]) + 1 + shift;
    j = base;
    for (int m = 0; m <= fin + 2; m++) begin
      @(negedge clk);
      if (m == 0) begin sw_start = 1'b0; tmr_pulse = 1'b0; wd_req = 1'b0; end
      if (j <= e && int'(m_off[j]) == m - 1 - shift) begin cur = m_pat[j]; j++; end
      chk({req, " R2 ctl"}, 32'(radio_ctl), 32'(cur));
      exp_irq = (m == fin && irq_mask[ibit]) ? (1 << ibit) : 0;
      chk({req, " R9 irq"}, 32'(seq_irq), 32'(exp_irq));
      if (inj > 0) begin
        if (m == inj + 1) begin chk("R6 err pulse", 32'(seq_err), 32'd1); sw_start = 1'b0; tmr_pulse = 1'b0; end
        else chk("R6 err quiet", 32'(seq_err), 32'd0);
        if (m == inj) begin if (start_src) tmr_pulse = 1'b1; else sw_start = 1'b1; end
      end
    end
  endtask

  task automatic up_phase(string req, bit tx, bit comb, bit tmr, int inj);
    @(negedge clk);
    sel_tx = tx; combined = comb; start_src = tmr;
    if (tmr) tmr_pulse = 1'b1; else sw_start = 1'b1;
    run_phase(req, up_base(tx, comb), rlen(comb), 0, tx ? 1 : 0, inj);
  endtask

  task automatic dn_phase(string req, bit tx, bit comb, int dly);
    @(negedge clk);
    wd_req = 1'b1; wd_delayed = (dly > 0); wd_delay = DW'(dly);
    run_phase(req, dn_base(tx, comb), rlen(comb), dly, 2, 0);
  endtask

  task automatic quiet(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk({req, " ctl"}, 32'(radio_ctl), 32'(cur));
      chk({req, " irq"}, 32'(seq_irq), 32'd0);
      chk({req, " err"}, 32'(seq_err), 32'd0);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_off = '0; tbl_pat = '0; tbl_last = 1'b0;
    start_src = 1'b0; sw_start = 1'b0; tmr_pulse = 1'b0; sel_tx = 1'b0; combined = 1'b0;
    wd_req = 1'b0; wd_delayed = 1'b0; wd_delay = '0; irq_mask = 3'b111;
    ovr_en = '0; ovr_val = '0; cur = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 ctl", 32'(radio_ctl), 32'd0);
    chk("R1 irq", 32'(seq_irq), 32'd0);
    chk("R1 err", 32'(seq_err), 32'd0);

    for (int r = 0; r < 4; r++) fill(r * Q, Q, 1'b0);

    // R8: warm-down request while idle does nothing
    @(negedge clk); wd_req = 1'b1; wd_delayed = 1'b0;
    @(negedge clk); wd_req = 1'b0;
    quiet("R8 wd idle", 4);

    // R3: separate layout, receive then transmit
    up_phase("R3 rx up", 1'b0, 1'b0, 1'b0, 0);
    dn_phase("R3 rx dn", 1'b0, 1'b0, 0);
    up_phase("R3 tx up", 1'b1, 1'b0, 1'b0, 0);
    dn_phase("R3 tx dn", 1'b1, 1'b0, 0);

    // R4: combined layout, select ignored
    fill(0, 2 * Q, 1'b0); fill(2 * Q, 2 * Q, 1'b0);
    up_phase("R4 tx up", 1'b1, 1'b1, 1'b0, 0);
    dn_phase("R4 tx dn", 1'b1, 1'b1, 0);
    up_phase("R4 rx up", 1'b0, 1'b1, 1'b0, 0);
    dn_phase("R4 rx dn", 1'b0, 1'b1, 0);

    // R5: unselected sources ignored
    @(negedge clk); start_src = 1'b1; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    quiet("R5 sw ignored", 4);
    @(negedge clk); start_src = 1'b0; tmr_pulse = 1'b1;
    @(negedge clk); tmr_pulse = 1'b0;
    quiet("R5 tmr ignored", 4);
    up_phase("R5 tmr up", 1'b0, 1'b1, 1'b1, 0);
    dn_phase("R5 tmr dn", 1'b0, 1'b1, 0);

    // R6: start while busy
    up_phase("R6 busy up", 1'b1, 1'b1, 1'b0, 2);
    // R10: override while holding
    @(negedge clk); ovr_en = 8'hF0; ovr_val = 8'hA5;
    @(negedge clk);
    chk("R10 ovr", 32'(radio_ctl), 32'((cur & 8'h0F) | 8'hA0));
    ovr_en = 8'h0F; ovr_val = 8'h3C;
    @(negedge clk);
    chk("R10 ovr low", 32'(radio_ctl), 32'((cur & 8'hF0) | 8'h0C));
    ovr_en = '0;
    @(negedge clk);
    chk("R10 ovr off", 32'(radio_ctl), 32'(cur));
    // R6: start in hold state is an error as well
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    chk("R6 err in hold", 32'(seq_err), 32'd1);
    @(negedge clk);
    chk("R6 err one cycle", 32'(seq_err), 32'd0);
    // R8: delayed warm-down
    dn_phase("R8 delayed dn", 1'b1, 1'b1, 5);
    up_phase("R8 up", 1'b0, 1'b1, 1'b0, 0);
    dn_phase("R8 delay one", 1'b0, 1'b1, 1);

    // R9: masking
    irq_mask = 3'b010;
    up_phase("R9 masked up", 1'b0, 1'b1, 1'b0, 0);
    dn_phase("R9 masked dn", 1'b0, 1'b1, 0);
    irq_mask = 3'b111;

    // R7: regions without last flag end on their final entry
    fill(0, Q, 1'b1); fill(Q, Q, 1'b1);
    up_phase("R7 rgn end up", 1'b0, 1'b0, 1'b0, 0);
    dn_phase("R7 rgn end dn", 1'b0, 1'b0, 2);
    fill(0, 2 * Q, 1'b1);
    up_phase("R7 comb end", 1'b1, 1'b1, 1'b0, 0);
    dn_phase("R7 comb dn", 1'b1, 1'b1, 0);

    // random sequences
    for (int it = 0; it < 12; it++) begin
      bit tx, cb, tm;
      int dly;
      tx = 1'($urandom_range(0, 1)); cb = 1'($urandom_range(0, 1));
      tm = 1'($urandom_range(0, 1)); dly = $urandom_range(0, 6);
      irq_mask = 3'($urandom_range(0, 7));
      fill(up_base(tx, cb), rlen(cb), 1'($urandom_range(0, 1)));
      fill(dn_base(tx, cb), rlen(cb), 1'b0);
      up_phase("R2 rand up", tx, cb, tm, (it % 3 == 0) ? 2 : 0);
      dn_phase("R2 rand dn", tx, cb, dly);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule